// File: doc/BRIEF.md
# Serial ADC host controller

This block is the host-side master for a three-wire serial analog-to-digital converter with an input multiplexer. A client hands it a request made of a channel number, a single-ended/differential choice and a polarity bit. The controller pulls chip select low and generates the serial clock from the system clock through a divider. On the data-in line it shifts out a start bit followed by the multiplexer assignment word. It then waits out the converter's sampling interval and its leading zero, and collects the result twice: once MSB first and once in the LSB-first copy that the converter sends right after it.

The two copies are compared. The result port delivers the MSB-first byte with a one-cycle valid strobe and an error bit that is set when the two copies disagree. After every conversion the controller raises chip select and keeps it high together with the serial clock for a programmable number of half periods, which resets the converter. Only then does it accept the next request. A build option lets the host release its data-in driver after the assignment word, so that data-in and data-out can share one board wire.

Top module: `adc_serial_host`

## Requirements
- R1: After reset and after every conversion, `adc_cs_n` and `adc_sclk` are both held high for exactly RST_HALVES*DIV_HALF system clocks before `req_ready` rises. `req_ready` is high only in that idle state, and `adc_sclk` is high whenever `adc_cs_n` is high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `adc_cs_n` and `adc_sclk` are low and `req_ready` is low, and no further request is accepted until R1's hold has ended.
- R3: While `adc_cs_n` is low, every serial clock half period lasts exactly DIV_HALF system clocks. One conversion has ADDR_BITS+SKIP+2*DATA_W-1 rising edges (22 with the defaults).
- R4: The data-in line carries a 1 (start), then the mode bit (1 = single-ended, 0 = differential), then the odd/sign bit, then `req_chan[CH_W-1:1]` MSB first. The odd/sign bit is `req_chan[0]` in single-ended mode and `req_swap` in differential mode, where `req_chan[0]` is ignored. Data-in changes only while the serial clock is low.
- R5: The first SKIP rising edges after the assignment word (the sampling gap and the leading zero) are not captured. The next DATA_W rising edges sample `adc_do` into `res_data`, MSB first.
- R6: `res_valid` is a single-cycle pulse after the last sample. `res_err` is 1 exactly when the LSB-first copy, which shares the LSB and is sampled on the following DATA_W-1 rising edges, does not reassemble to `res_data`.
- R7: With SHARED_DIO=1, `adc_di_oe` falls at the first falling serial clock edge after the last assignment bit and stays low until chip select rises. It is high at all other times. With SHARED_DIO=0 it is always high.
- R8: `adc_cs_n` stays low until the last sample has been taken and rises while `adc_sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_chan | input | CH_W | Channel (single-ended) or pair in upper bits (differential) |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_swap | input | 1 | Polarity of the differential pair |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DATA_W | MSB-first result byte |
| res_err | output | 1 | MSB-first and LSB-first copies differ |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_di | output | 1 | Serial data to converter |
| adc_di_oe | output | 1 | Drive enable for the data-in wire |
| adc_do | input | 1 | Serial data from converter |

## Verification
The bench builds the controller with DIV_HALF=3, RST_HALVES=4, SHARED_DIO=1 and eight channels. The short half period keeps a full conversion near 140 system clocks, so many conversions fit in a short run, while it still leaves several cycles per half to measure exact half lengths and hold lengths. With the shared-pin variant, the driver release can be seen against the converter model's first drive. The model shifts in the assignment word, drives the result in both orders, and can corrupt one LSB-first bit to provoke the mismatch flag.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_IDLE = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    // One capture opportunity, issued on a rising serial clock edge
    typedef struct packed {
        logic valid;
        logic msb_slot;
        logic lsb_slot;
        logic last;
    } samp_t;

    localparam int unsigned MIN_CH_W = 2;

endpackage

// File: rtl/adc_host_tick.sv
module adc_host_tick #(
    parameter int unsigned DIV_HALF = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
    import adc_host_pkg::*;
#(
    parameter int unsigned CH_W       = 3,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SKIP       = 2,
    parameter int unsigned RST_HALVES = 2,
    parameter bit          SHARED_DIO = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            req_valid,
    input  logic [CH_W-1:0] req_chan,
    input  logic            req_single,
    input  logic            req_swap,
    output logic            req_ready,
    output logic            run,
    output logic            sclk,
    output logic            cs_n,
    output logic            di,
    output logic            di_oe,
    output samp_t           samp
);
    localparam int unsigned ADDR_BITS = CH_W + 2;
    localparam int unsigned DSTART    = ADDR_BITS + SKIP;
    localparam int unsigned MSB_END   = DSTART + DATA_W;
    localparam int unsigned LSB_START = DSTART + DATA_W - 1;
    localparam int unsigned CYCLES    = DSTART + 2 * DATA_W - 1;
    localparam int unsigned HALVES    = 2 * CYCLES;
    localparam int unsigned HW        = $clog2(HALVES);
    localparam int unsigned HOLD_W    = (RST_HALVES > 1) ? $clog2(RST_HALVES) : 1;

    phase_e                phase_q;
    logic [HW-1:0]         half_q;
    logic [HOLD_W-1:0]     hold_q;
    logic [ADDR_BITS-1:0]  addr_q;
    logic                  sclk_q;
    logic                  cs_q;
    logic                  di_q;

    logic [ADDR_BITS-1:0]  addr_word;
    logic [HW-1:0]         cyc;
    logic                  fall_ev;
    logic                  end_ev;

    // start, mode, odd/sign, select bits (MSB first)
    assign addr_word = {1'b1, req_single,
                        (req_single ? req_chan[0] : req_swap),
                        req_chan[CH_W-1:1]};

    assign cyc     = half_q >> 1;
    assign end_ev  = tick && (phase_q == PH_RUN) && (half_q == HW'(HALVES - 1));
    assign fall_ev = tick && (phase_q == PH_RUN) && half_q[0] && !end_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HOLD;
            half_q  <= '0;
            hold_q  <= '0;
            addr_q  <= '0;
            sclk_q  <= 1'b1;
            cs_q    <= 1'b1;
            di_q    <= 1'b0;
        end else begin
            case (phase_q)
                PH_HOLD: begin
                    if (tick) begin
                        if (hold_q == HOLD_W'(RST_HALVES - 1)) begin
                            phase_q <= PH_IDLE;
                            hold_q  <= '0;
                        end else begin
                            hold_q <= hold_q + 1'b1;
                        end
                    end
                end
                PH_IDLE: begin
                    if (req_valid) begin
                        phase_q <= PH_RUN;
                        half_q  <= '0;
                        sclk_q  <= 1'b0;
                        cs_q    <= 1'b0;
                        addr_q  <= addr_word;
                        di_q    <= addr_word[ADDR_BITS-1];
                    end
                end
                PH_RUN: begin
                    if (end_ev) begin
                        phase_q <= PH_HOLD;
                        half_q  <= '0;
                        hold_q  <= '0;
                        cs_q    <= 1'b1;
                        di_q    <= 1'b0;
                    end else if (tick) begin
                        half_q <= half_q + 1'b1;
                        sclk_q <= ~sclk_q;
                        if (fall_ev) begin
                            di_q   <= addr_q[ADDR_BITS-2];
                            addr_q <= {addr_q[ADDR_BITS-2:0], 1'b0};
                        end
                    end
                end
                default: phase_q <= PH_HOLD;
            endcase
        end
    end

    generate
        if (SHARED_DIO) begin : gen_shared
            logic release_q;
            always_ff @(posedge clk) begin
                if (rst || phase_q != PH_RUN || end_ev) begin
                    release_q <= 1'b0;
                end else if (fall_ev && cyc == HW'(ADDR_BITS - 1)) begin
                    release_q <= 1'b1;
                end
            end
            assign di_oe = ~release_q;
        end else begin : gen_dedicated
            assign di_oe = 1'b1;
        end
    endgenerate

    always_comb begin
        samp.valid    = tick && (phase_q == PH_RUN) && !half_q[0];
        samp.msb_slot = (cyc >= HW'(DSTART)) && (cyc < HW'(MSB_END));
        samp.lsb_slot = (cyc >= HW'(LSB_START));
        samp.last     = (half_q == HW'(HALVES - 2));
    end

    assign req_ready = (phase_q == PH_IDLE);
    assign run       = (phase_q != PH_IDLE);
    assign sclk      = sclk_q;
    assign cs_n      = cs_q;
    assign di        = di_q;

endmodule

// File: rtl/adc_host_cap.sv
module adc_host_cap
    import adc_host_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  samp_t             samp,
    input  logic              bit_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_err
);
    logic [DATA_W-1:0] msb_q;
    logic [DATA_W-1:0] lsb_q;
    logic [DATA_W-1:0] lsb_nxt;
    logic              valid_q;
    logic [DATA_W-1:0] data_q;
    logic              err_q;

    // LSB-first stream shifts in from the top, so it lands in natural order
    assign lsb_nxt = {bit_in, lsb_q[DATA_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            msb_q   <= '0;
            lsb_q   <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (samp.valid) begin
                if (samp.msb_slot) begin
                    msb_q <= {msb_q[DATA_W-2:0], bit_in};
                end
                if (samp.lsb_slot) begin
                    lsb_q <= lsb_nxt;
                end
                if (samp.last) begin
                    valid_q <= 1'b1;
                    data_q  <= msb_q;
                    err_q   <= (lsb_nxt != msb_q);
                end
            end
        end
    end

    assign res_valid = valid_q;
    assign res_data  = data_q;
    assign res_err   = err_q;

endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
    import adc_host_pkg::*;
#(
    parameter int unsigned N_CH       = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned DIV_HALF   = 7,
    parameter int unsigned RST_HALVES = 2,
    parameter int unsigned SKIP       = 2,
    parameter bit          SHARED_DIO = 1'b0,
    localparam int unsigned CH_W      = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              req_single,
    input  logic              req_swap,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_err,
    output logic              adc_sclk,
    output logic              adc_cs_n,
    output logic              adc_di,
    output logic              adc_di_oe,
    input  logic              adc_do
);
    logic  run;
    logic  tick;
    samp_t samp;

    adc_host_tick #(
        .DIV_HALF (DIV_HALF)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    adc_host_seq #(
        .CH_W       (CH_W),
        .DATA_W     (DATA_W),
        .SKIP       (SKIP),
        .RST_HALVES (RST_HALVES),
        .SHARED_DIO (SHARED_DIO)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .req_valid  (req_valid),
        .req_chan   (req_chan),
        .req_single (req_single),
        .req_swap   (req_swap),
        .req_ready  (req_ready),
        .run        (run),
        .sclk       (adc_sclk),
        .cs_n       (adc_cs_n),
        .di         (adc_di),
        .di_oe      (adc_di_oe),
        .samp       (samp)
    );

    adc_host_cap #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .samp      (samp),
        .bit_in    (adc_do),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_err   (res_err)
    );

endmodule

// File: rtl/adc_serial_host_chk.sv
module adc_serial_host_chk #(
    parameter int unsigned DIV_HALF = 7
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic res_valid,
    input logic adc_sclk,
    input logic adc_cs_n,
    input logic adc_di,
    input logic adc_di_oe
);
    logic        sclk_d;
    logic [15:0] len_q;

    // len_q holds the length of the serial clock run that ended last cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b1;
            len_q  <= '0;
        end else begin
            sclk_d <= adc_sclk;
            if (adc_sclk != sclk_d) begin
                len_q <= 16'd1;
            end else if (len_q != 16'hFFFF) begin
                len_q <= len_q + 16'd1;
            end
        end
    end

    a_r1_ready_only_deselected: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (adc_cs_n && adc_sclk));

    a_r1_sclk_low_only_selected: assert property (@(posedge clk) disable iff (rst)
        !adc_sclk |-> !adc_cs_n);

    a_r2_accept_selects: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!adc_cs_n && !adc_sclk && !req_ready));

    a_r3_half_len: assert property (@(posedge clk) disable iff (rst)
        (!adc_cs_n && $past(!adc_cs_n) && adc_sclk != sclk_d) |-> (len_q == 16'(DIV_HALF)));

    a_r4_di_stable_high: assert property (@(posedge clk) disable iff (rst)
        (!adc_cs_n && adc_sclk && $past(adc_sclk)) |-> $stable(adc_di));

    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    a_r7_release_selected: assert property (@(posedge clk) disable iff (rst)
        !adc_di_oe |-> !adc_cs_n);

    a_r8_deselect_clock_high: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_n) |-> adc_sclk);

endmodule

bind adc_serial_host adc_serial_host_chk #(
    .DIV_HALF (DIV_HALF)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .adc_sclk  (adc_sclk),
    .adc_cs_n  (adc_cs_n),
    .adc_di    (adc_di),
    .adc_di_oe (adc_di_oe)
);

// File: tb/adc_serial_host_bench.sv
module adc_serial_host_bench;
    localparam int unsigned DIVH  = 3;
    localparam int unsigned RHALV = 4;
    localparam int unsigned AW    = 4;   // assignment bits after the start bit
    localparam int unsigned RISES = 1 + AW + 2 + 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_chan = '0;
    logic       req_single = 1'b0;
    logic       req_swap = 1'b0;
    logic       res_valid;
    logic [7:0] res_data;
    logic       res_err;
    logic       adc_sclk, adc_cs_n, adc_di, adc_di_oe;
    logic       adc_do = 1'b0;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    adc_serial_host #(
        .N_CH (8), .DATA_W (8), .DIV_HALF (DIVH), .RST_HALVES (RHALV),
        .SKIP (2), .SHARED_DIO (1'b1)
    ) u_adc_serial_host (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_ready (req_ready),
        .req_chan (req_chan), .req_single (req_single), .req_swap (req_swap),
        .res_valid (res_valid), .res_data (res_data), .res_err (res_err),
        .adc_sclk (adc_sclk), .adc_cs_n (adc_cs_n), .adc_di (adc_di),
        .adc_di_oe (adc_di_oe), .adc_do (adc_do)
    );

    // ---------------- converter model ----------------
    logic [7:0]    m_byte = '0;
    logic          m_corrupt = 1'b0;
    logic [AW-1:0] m_addr;
    logic          m_started, m_addr_done;
    int            m_acnt, m_fall, m_rises, m_run, m_hmin, m_hmax, m_di_bad, m_oe_bad;
    logic          p_cs = 1'b1, p_sclk = 1'b1, p_di = 1'b0;

    always @(negedge clk) begin
        if (!adc_cs_n && p_cs) begin
            m_addr = '0; m_started = 1'b0; m_addr_done = 1'b0;
            m_acnt = 0; m_fall = 0; m_rises = 0; m_run = 1;
            m_hmin = 1000; m_hmax = 0; m_di_bad = 0; m_oe_bad = 0;
            adc_do = 1'b0;
        end else if (!adc_cs_n) begin
            if (adc_sclk && p_sclk && adc_di != p_di) m_di_bad++;
            if (adc_sclk != p_sclk) begin
                if (m_run < m_hmin) m_hmin = m_run;
                if (m_run > m_hmax) m_hmax = m_run;
                m_run = 1;
                if (adc_sclk) begin
                    m_rises++;
                    if (!m_addr_done) begin
                        if (!adc_di_oe) m_oe_bad++;
                        if (!m_started) begin
                            if (adc_di) m_started = 1'b1;
                        end else begin
                            m_addr = {m_addr[AW-2:0], adc_di};
                            m_acnt++;
                            if (m_acnt == AW) m_addr_done = 1'b1;
                        end
                    end
                end else if (m_addr_done) begin
                    m_fall++;
                    if (adc_di_oe) m_oe_bad++;
                    if (m_fall >= 3 && m_fall <= 10)
                        adc_do = m_byte[10 - m_fall];
                    else if (m_fall >= 11 && m_fall <= 17)
                        adc_do = m_byte[m_fall - 10] ^ (m_corrupt && m_fall == 14);
                    else
                        adc_do = 1'b0;
                end
            end else begin
                m_run++;
            end
        end
        p_cs = adc_cs_n; p_sclk = adc_sclk; p_di = adc_di;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic measure_hold(input string tag);
        int  n = 0;
        bit  low_seen = 0;
        while (!req_ready) begin
            @(negedge clk);
            n++;
            if (!adc_sclk || !adc_cs_n) low_seen = 1;
            if (n > 5000) break;
        end
        check(n == int'(RHALV * DIVH), {tag, " hold length"}, n, RHALV * DIVH);
        check(!low_seen, {tag, " cs/sclk high in hold"}, low_seen, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        check(adc_cs_n && adc_sclk, "R1 reset pins", {adc_cs_n, adc_sclk}, 3);
        check(!req_ready && !res_valid, "R1 reset ready/valid", {req_ready, res_valid}, 0);
        rst = 1'b0;
        measure_hold("R1 after reset");
    endtask

    task automatic t_convert(input bit single, input logic [2:0] chan, input bit swap,
                             input logic [7:0] val, input bit corrupt);
        logic [AW-1:0] exp_addr;
        logic [7:0]    got;
        bit            gerr, busy_bad, cs_bad;
        int            guard;
        exp_addr = {single, (single ? chan[0] : swap), chan[2:1]};
        while (!req_ready) @(negedge clk);
        m_byte = val; m_corrupt = corrupt;
        req_single = single; req_chan = chan; req_swap = swap; req_valid = 1'b1;
        @(negedge clk);
        check(!adc_cs_n && !adc_sclk, "R2 select after accept", {adc_cs_n, adc_sclk}, 0);
        check(!req_ready, "R2 ready low when busy", req_ready, 0);
        busy_bad = 0; cs_bad = 0; guard = 0;
        while (!res_valid && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (req_ready) busy_bad = 1;
            if (adc_cs_n) cs_bad = 1;
        end
        got = res_data; gerr = res_err;
        req_valid = 1'b0;
        check(!busy_bad, "R2 no accept while busy", busy_bad, 0);
        check(!cs_bad, "R8 cs low until result", cs_bad, 0);
        check(got == val, "R5 result byte", got, val);
        check(gerr == corrupt, "R6 mismatch flag", gerr, corrupt);
        @(negedge clk);
        check(!res_valid, "R6 single-cycle strobe", res_valid, 0);
        while (!adc_cs_n) @(negedge clk);
        check(adc_sclk, "R8 sclk high at deselect", adc_sclk, 1);
        check(m_addr_done && m_addr == exp_addr, "R4 assignment word", m_addr, exp_addr);
        check(m_di_bad == 0, "R4 data-in stable while high", m_di_bad, 0);
        check(m_rises == int'(RISES), "R3 rising edge count", m_rises, RISES);
        check(m_hmin == int'(DIVH) && m_hmax == int'(DIVH), "R3 half length",
              m_hmin * 256 + m_hmax, DIVH * 256 + DIVH);
        check(m_oe_bad == 0, "R7 driver release timing", m_oe_bad, 0);
        check(adc_di_oe, "R7 driver back on after deselect", adc_di_oe, 1);
        measure_hold("R1 between conversions");
    endtask

    initial begin
        t_reset();
        t_convert(1'b1, 3'd0, 1'b0, 8'hA5, 1'b0);
        t_convert(1'b1, 3'd5, 1'b0, 8'h00, 1'b0);
        t_convert(1'b1, 3'd7, 1'b1, 8'hFF, 1'b0);
        t_convert(1'b0, 3'd2, 1'b0, 8'h5A, 1'b0);
        t_convert(1'b0, 3'd3, 1'b1, 8'h01, 1'b0);  // r4_ chan[0] ignored in differential
        t_convert(1'b0, 3'd6, 1'b0, 8'h80, 1'b1);  // r6_ corrupted LSB-first copy
        t_convert(1'b1, 3'd3, 1'b0, 8'h3C, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule